// File: doc/BRIEF.md
# Interrupt Event Register Bank

This block collects single-cycle event pulses from a serial flash engine and presents them to software as memory-mapped interrupt registers. Each event source owns one bit. A pulse latches its bit into a sticky raw status word. A separate enable mask decides which latched events reach the single level-sensitive interrupt line.

Software never writes the enable mask directly. One offset sets mask bits wherever the written word holds a one, and another offset clears them the same way. Status can be read in two forms: the raw word, and a masked word holding only enabled pending events. Writing ones to the masked word acknowledges those events. Writing ones to the raw word forces events, which is useful for testing the interrupt path. By default two sources are present: bit 0 is frame-complete and bit 1 is word-complete.

Reads are combinational from the register state: `bus_rdata_o` reflects `bus_addr_i` in the same cycle. Writes take effect at the clock edge on which `bus_wr_i` is high.

Top module: `irq_bank`

## Requirements
- R1: After reset every raw and enable bit is zero, `irq_o` is low, and all four register offsets read zero.
- R2: An event pulse on `evt_pulse_i[i]` sets raw bit i at that clock edge, and the bit stays set until it is cleared. Raw status reads at byte offset 0x20, with bit 0 for frame-complete and bit 1 for word-complete.
- R3: A write to offset 0x20 sets every raw bit whose data bit is one. Data bits that are zero leave the raw bits unchanged.
- R4: A write to offset 0x28 sets every enable bit whose data bit is one and leaves the other enable bits unchanged. Reads of offset 0x28 and of offset 0x2C both return the enable mask.
- R5: A write to offset 0x2C clears every enable bit whose data bit is one and leaves the other enable bits unchanged.
- R6: Offset 0x24 reads the raw word ANDed with the enable mask, so it reads zero when no enabled event is pending.
- R7: A write to offset 0x24 clears every raw bit whose data bit is one. Data bits that are zero leave the raw bits unchanged.
- R8: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when at least one bit is both raw-pending and enabled.
- R10: Read bits above the event bits are zero. Offsets other than the four listed read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_pulse_i | input | NUM_EVT | Event pulses, one per source |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions assume that the bus performs at most one write per cycle and that every address is a full byte address compared exactly, so a write is never split across two offsets. They also assume that event pulses may arrive in any cycle, including cycles that carry a write to the same bit.

The random stimulus follows these rules. Each cycle it picks one address from the four mapped offsets plus one unmapped offset, issues at most one write, and raises events with low probability. Directed steps then force the event-against-clear collision.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int unsigned OFF_RAW  = 32'h20;
    localparam int unsigned OFF_MSK  = 32'h24;
    localparam int unsigned OFF_ESET = 32'h28;
    localparam int unsigned OFF_ECLR = 32'h2C;

    typedef struct packed {
        logic raw;
        logic msk;
        logic eset;
        logic eclr;
    } reg_sel_t;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    always_comb begin
        sel_o.raw  = (addr_i == ADDR_W'(OFF_RAW));
        sel_o.msk  = (addr_i == ADDR_W'(OFF_MSK));
        sel_o.eset = (addr_i == ADDR_W'(OFF_ESET));
        sel_o.eclr = (addr_i == ADDR_W'(OFF_ECLR));
    end
endmodule

// File: rtl/irq_evt_slice.sv
module irq_evt_slice
    import irq_bank_pkg::*;
(
    input  logic     raw_q_i,
    input  logic     en_q_i,
    input  logic     evt_i,
    input  logic     wr_i,
    input  reg_sel_t sel_i,
    input  logic     wbit_i,
    output logic     raw_d_o,
    output logic     en_d_o
);
    logic set_raw, clr_raw, set_en, clr_en;

    always_comb begin
        set_raw = evt_i | (wr_i & sel_i.raw & wbit_i);
        clr_raw = wr_i & sel_i.msk & wbit_i;
        set_en  = wr_i & sel_i.eset & wbit_i;
        clr_en  = wr_i & sel_i.eclr & wbit_i;
        // a set (event) has priority over an acknowledge in the same cycle
        raw_d_o = set_raw | (raw_q_i & ~clr_raw);
        en_d_o  = set_en  | (en_q_i & ~clr_en);
    end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_EVT = 2,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] evt_pulse_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o
);
    localparam int PAD_W = DATA_W - NUM_EVT;

    typedef struct packed {
        logic [NUM_EVT-1:0] raw;
        logic [NUM_EVT-1:0] en;
    } bank_t;

    bank_t              state_d, state_q;
    reg_sel_t           sel;
    logic [NUM_EVT-1:0] raw_nx, en_nx;
    logic [NUM_EVT-1:0] raw_vis, en_vis, pend;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_slice
        irq_evt_slice u_slice (
            .raw_q_i (state_q.raw[i]),
            .en_q_i  (state_q.en[i]),
            .evt_i   (evt_pulse_i[i]),
            .wr_i    (bus_wr_i),
            .sel_i   (sel),
            .wbit_i  (bus_wdata_i[i]),
            .raw_d_o (raw_nx[i]),
            .en_d_o  (en_nx[i])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.raw = raw_nx;
        state_d.en  = en_nx;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign raw_vis = state_q.raw;
    assign en_vis  = state_q.en;
    assign pend    = state_q.raw & state_q.en;
    assign irq_o   = |pend;

    always_comb begin
        bus_rdata_o = '0;
        unique case (1'b1)
            sel.raw:             bus_rdata_o = {{PAD_W{1'b0}}, state_q.raw};
            sel.msk:             bus_rdata_o = {{PAD_W{1'b0}}, pend};
            sel.eset, sel.eclr:  bus_rdata_o = {{PAD_W{1'b0}}, state_q.en};
            default:             bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int NUM_EVT = 2,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_EVT-1:0] evt_pulse_i,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] raw,
    input logic [NUM_EVT-1:0] en
);
    logic w_raw, w_msk, w_set, w_clr;
    assign w_raw = bus_wr_i && bus_addr_i == ADDR_W'(OFF_RAW);
    assign w_msk = bus_wr_i && bus_addr_i == ADDR_W'(OFF_MSK);
    assign w_set = bus_wr_i && bus_addr_i == ADDR_W'(OFF_ESET);
    assign w_clr = bus_wr_i && bus_addr_i == ADDR_W'(OFF_ECLR);

    AST_EVT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_pulse_i != '0) |=> ((raw & $past(evt_pulse_i)) == $past(evt_pulse_i))); // R8
    AST_RAW_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_pulse_i == '0 && !w_raw) |=> ((raw & ~$past(raw)) == '0)); // R2
    AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_set |=> ((en & $past(bus_wdata_i[NUM_EVT-1:0])) == $past(bus_wdata_i[NUM_EVT-1:0]))); // R4
    AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_clr |=> ((en & $past(bus_wdata_i[NUM_EVT-1:0])) == '0)); // R5
    AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(w_set || w_clr) |=> $stable(en)); // R4
    AST_MASKED_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == ADDR_W'(OFF_MSK)) |-> (bus_rdata_o[NUM_EVT-1:0] == (raw & en))); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((raw & en) != '0)); // R9
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_rdata_o[DATA_W-1:NUM_EVT] == '0); // R10
    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_msk |=> ((raw & $past(bus_wdata_i[NUM_EVT-1:0]) & ~$past(evt_pulse_i)) == '0)); // R7
endmodule

bind irq_bank irq_bank_chk #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_pulse_i (evt_pulse_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .raw         (raw_vis),
    .en          (en_vis)
);

// File: tb/tb_irq_bank.sv
module tb_irq_bank;
    localparam int N  = 2;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_RAW = 8'h20, A_MSK = 8'h24, A_SET = 8'h28,
                              A_CLR = 8'h2C, A_BAD = 8'h30;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [N-1:0]  evt = '0;
    logic          wr = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0, fails = 0;
    logic [N-1:0] m_raw = '0, m_en = '0;

    always #2 clk = ~clk;

    irq_bank #(.NUM_EVT(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_pulse_i(evt), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
        case (a)
            A_RAW:        return DW'(m_raw);
            A_MSK:        return DW'(m_raw & m_en);
            A_SET, A_CLR: return DW'(m_en);
            default:      return '0;
        endcase
    endfunction

    task automatic model(logic [N-1:0] e, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
        logic [N-1:0] db = d[N-1:0];
        if (w && a == A_RAW) m_raw = m_raw | db;
        if (w && a == A_MSK) m_raw = m_raw & ~db;
        if (w && a == A_SET) m_en = m_en | db;
        if (w && a == A_CLR) m_en = m_en & ~db;
        m_raw = m_raw | e;
    endtask

    task automatic step(logic [N-1:0] e, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        evt = e; wr = w; addr = a; wdata = d;
        @(posedge clk);
        model(e, w, a, d);
    endtask

    task automatic check_rd(logic [AW-1:0] a, string req);
        logic [DW-1:0] ex;
        @(negedge clk);
        evt = '0; wr = 0; addr = a; wdata = '0;
        #1;
        ex = exp_read(a);
        checks++;
        if (rdata !== ex) begin
            fails++;
            $display("FAIL %s read addr %h: got %h expected %h", req, a, rdata, ex);
        end
        checks++;
        if (irq !== |(m_raw & m_en)) begin
            fails++;
            $display("FAIL R9 irq: got %b expected %b", irq, |(m_raw & m_en));
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] alist [5];
        alist[0] = A_RAW; alist[1] = A_MSK; alist[2] = A_SET; alist[3] = A_CLR; alist[4] = A_BAD;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        check_rd(A_RAW, "R1"); check_rd(A_MSK, "R1");
        check_rd(A_SET, "R1"); check_rd(A_CLR, "R1");

        // R2 word-complete event at bit 1, masked view stays zero (R6)
        step(2'b10, 0, A_BAD, 0);
        check_rd(A_RAW, "R2"); check_rd(A_MSK, "R6");
        // R4 enable set, R9 irq rises
        step(0, 1, A_SET, 32'h2);
        check_rd(A_SET, "R4"); check_rd(A_MSK, "R9");
        // R7 zero write to masked view does nothing, then ack
        step(0, 1, A_MSK, 32'h0);
        check_rd(A_RAW, "R7");
        step(0, 1, A_MSK, 32'h2);
        check_rd(A_RAW, "R7");
        // R3 force frame-complete, zero write has no effect
        step(0, 1, A_RAW, 32'h0);
        check_rd(A_RAW, "R3");
        step(0, 1, A_RAW, 32'h1);
        check_rd(A_RAW, "R3");
        // R8 event and acknowledge collide on bit 0
        step(2'b01, 1, A_MSK, 32'h1);
        check_rd(A_RAW, "R8");
        // R5 enable clear, readable at the clear offset
        step(0, 1, A_SET, 32'h3);
        step(0, 1, A_CLR, 32'h1);
        check_rd(A_CLR, "R5"); check_rd(A_MSK, "R6");
        // R10 unmapped write ignored, upper bits zero
        step(0, 1, A_BAD, 32'hFFFF_FFFF);
        check_rd(A_BAD, "R10"); check_rd(A_RAW, "R10"); check_rd(A_SET, "R10");
        step(0, 1, A_SET, 32'hFFFF_FFFF);
        check_rd(A_SET, "R10");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] e;
            e = (($urandom % 4) == 0) ? N'($urandom) : '0;
            step(e, ($urandom % 4) != 0, alist[$urandom % 5], $urandom);
            if (k % 2 == 0) check_rd(alist[$urandom % 5], "R2-R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule